// File: doc/BRIEF.md
# Two-Wire Bus Slave Engine with Software Status Handshake

This block is the slave half of a register-driven two-wire (I2C) controller. It watches the already-synchronised SCL and SDA lines and drives open-drain pull-down enables for both. Each bus event moves the engine to a numbered status code and raises an interrupt flag. If SCL is low, or once it next goes low, the engine holds it low until software writes the flag back to zero. Software therefore handles the transfer one byte at a time: it reads the status code and any received byte, and it loads the next byte to send.

One acknowledge-enable bit does two jobs. It decides whether the engine answers its own 7-bit address or a general call at all. It also decides whether each received byte is acknowledged. In transmit mode, clearing it marks the byte being loaded as the last one. A general-call enable bit gates the response to address zero. The interrupt output follows the flag, gated by an interrupt-enable bit.

Top module: `twi_slave_engine`

## Requirements
- R1: After reset the status code is F8h, the flag and interrupt are 0 and neither line is driven. A return to F8h never sets the flag.
- R2: With acknowledge-enable at 1, an own-address write is acknowledged with SDA low in the ninth clock. The status becomes 60h and the flag is set.
- R3: While the flag is 1, the engine holds SCL low once SCL is low. It keeps holding for any length of software delay and lets go within two cycles of software clearing the flag.
- R4: The interrupt output is 1 exactly when interrupt-enable and the flag are both 1, and it drops once the flag is cleared.
- R5: Received data bytes are assembled MSB first and presented as received data. They are acknowledged (SDA low, status 80h) when acknowledge-enable is 1 at the eighth bit. Otherwise they are not acknowledged (SDA high, status 88h), the engine ignores the bus until the next START, and clearing the flag returns it to F8h.
- R6: Address 0 with write direction is acknowledged (status 70h) only when both acknowledge-enable and general-call enable are 1. General-call data bytes report 90h with ACK and 98h with NACK.
- R7: With acknowledge-enable at 0, the own address is left unacknowledged (SDA high), the flag stays 0 and the status stays F8h. A non-matching address gets the same treatment.
- R8: An own-address read is acknowledged with status A8h. After each flag clear, the byte on the transmit-data input is sent MSB first. A master ACK then gives B8h and a master NACK gives C0h.
- R9: If acknowledge-enable is 0 when a transmit byte is loaded, that byte is the last. A master ACK after it gives C8h, and clearing the flag after C8h or C0h gives F8h.
- R10: A STOP, or a repeated START, while the engine is addressed gives status A0h and sets the flag. Clearing it gives F8h. A repeated START then accepts a new address.
- R11: The engine changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 (clock stretch) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ack_en | input | 1 | Acknowledge enable / not-last-byte marker |
| gc_en | input | 1 | Answer the general call address |
| irq_en | input | 1 | Interrupt enable |
| own_addr | input | 7 | Own 7-bit slave address |
| tx_data | input | 8 | Byte to send, taken when the flag is cleared in transmit |
| flag_clr | input | 1 | One-cycle pulse: software writes 0 to the flag |
| status | output | 8 | Current status code |
| rx_data | output | 8 | Last received byte |
| irq_flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench acts as a bus master on a wired-AND model. Directed sequences cover address rejection (acknowledge disabled, wrong address, general call disabled), repeated START while addressed, the last-byte path and the master-NACK path. Random write, general-call and read transfers vary the byte count, the per-byte acknowledge setting, the transmit data, the interrupt enable and the software service delay. Together they separate 80h from 88h, 90h from 98h, and B8h from C0h and C8h. They also show whether the clock stretch lasts for the whole service delay.

// File: rtl/twi_slv_pkg.sv
// Shared constants and types for the two-wire slave engine.
// Assumes 7-bit addressing and 8-bit bytes on the bus.
package twi_slv_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [BYTE_W-1:0] ST_IDLE    = 8'hF8;
    localparam logic [BYTE_W-1:0] ST_SLA_W   = 8'h60;
    localparam logic [BYTE_W-1:0] ST_GCALL   = 8'h70;
    localparam logic [BYTE_W-1:0] ST_RX_ACK  = 8'h80;
    localparam logic [BYTE_W-1:0] ST_RX_NACK = 8'h88;
    localparam logic [BYTE_W-1:0] ST_GC_ACK  = 8'h90;
    localparam logic [BYTE_W-1:0] ST_GC_NACK = 8'h98;
    localparam logic [BYTE_W-1:0] ST_STOPPED = 8'hA0;
    localparam logic [BYTE_W-1:0] ST_SLA_R   = 8'hA8;
    localparam logic [BYTE_W-1:0] ST_TX_ACK  = 8'hB8;
    localparam logic [BYTE_W-1:0] ST_TX_NACK = 8'hC0;
    localparam logic [BYTE_W-1:0] ST_TX_LAST = 8'hC8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_RX, PH_RX_ACK, PH_TX, PH_TX_ACK, PH_SKIP
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;
endpackage

// File: rtl/twi_slv_linemon.sv
// Line monitor: turns SCL/SDA levels into edge and START/STOP events.
// Assumes both inputs are already synchronised to clk; the lines idle high.
module twi_slv_linemon
    import twi_slv_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    // Keep the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode events from the previous and present levels.
    always_comb begin
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/twi_slv_hold.sv
// Clock-stretch and interrupt stage: holds SCL low while the flag is set.
// Assumes the flag comes from a register; the hold is latched only once SCL
// is seen low, so a flag raised while SCL is high never forces a low pulse.
module twi_slv_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic irq_en,
    input  logic scl_i,
    output logic scl_oe,
    output logic irq
);
    logic hold_q;

    // Grab SCL once it is low and keep it while the flag stays set.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= flag & (hold_q | ~scl_i);
    end

    assign scl_oe = hold_q;
    assign irq    = irq_en & flag;
endmodule

// File: rtl/twi_slv_core.sv
// Slave protocol engine: address match, byte shifting, ACK slots, status codes.
// Assumes events from twi_slv_linemon; SDA is only updated on SCL falling
// edges or while software holds the bus stretched.
module twi_slv_core
    import twi_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              sda_i,
    input  logic              ack_en,
    input  logic              gc_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data,
    output logic              flag,
    output logic              sda_oe
);
    phase_t            phase;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              rw, is_gc, ackd, mack, last, tx_pend;
    logic              addressed, terminal, own_hit, gc_hit;

    // Classify the current phase and status for the STOP and clear paths.
    always_comb begin
        addressed = (phase == PH_RX) || (phase == PH_RX_ACK) ||
                    (phase == PH_TX) || (phase == PH_TX_ACK);
        terminal  = (status == ST_RX_NACK) || (status == ST_GC_NACK) ||
                    (status == ST_STOPPED) || (status == ST_TX_NACK) ||
                    (status == ST_TX_LAST);
        own_hit   = shreg[BYTE_W-1:1] == own_addr;
        gc_hit    = (shreg[BYTE_W-1:1] == '0) && !shreg[0];
    end

    // Main sequencer: software clear first, then bus events override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            status  <= ST_IDLE;
            rx_data <= '0;
            flag    <= 1'b0;
            sda_oe  <= 1'b0;
            rw      <= 1'b0;
            is_gc   <= 1'b0;
            ackd    <= 1'b0;
            mack    <= 1'b0;
            last    <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            if (flag_clr && flag) begin
                flag <= 1'b0;
                if (terminal) status <= ST_IDLE;
                if (tx_pend) begin
                    shreg   <= tx_data;
                    sda_oe  <= ~tx_data[BYTE_W-1];
                    last    <= ~ack_en;
                    cnt     <= '0;
                    tx_pend <= 1'b0;
                end
            end
            if (ev.start) begin
                if (addressed) begin
                    status <= ST_STOPPED;
                    flag   <= 1'b1;
                end
                phase   <= PH_ADDR;
                cnt     <= '0;
                sda_oe  <= 1'b0;
                tx_pend <= 1'b0;
            end else if (ev.stop) begin
                if (addressed) begin
                    status <= ST_STOPPED;
                    flag   <= 1'b1;
                end
                phase   <= PH_IDLE;
                sda_oe  <= 1'b0;
                tx_pend <= 1'b0;
            end else begin
                case (phase)
                    PH_ADDR, PH_RX: begin
                        if (ev.rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_i};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == CNT_W'(BYTE_W)) begin
                            cnt <= '0;
                            if (phase == PH_ADDR) begin
                                if (ack_en && (own_hit || (gc_hit && gc_en))) begin
                                    sda_oe <= 1'b1;
                                    rw     <= shreg[0];
                                    is_gc  <= gc_hit;
                                    phase  <= PH_ADDR_ACK;
                                end else begin
                                    phase <= PH_SKIP;
                                end
                            end else begin
                                rx_data <= shreg;
                                ackd    <= ack_en;
                                sda_oe  <= ack_en;
                                phase   <= PH_RX_ACK;
                            end
                        end
                    end
                    PH_ADDR_ACK: begin
                        if (ev.fall) begin
                            sda_oe  <= 1'b0;
                            flag    <= 1'b1;
                            status  <= rw ? ST_SLA_R : (is_gc ? ST_GCALL : ST_SLA_W);
                            phase   <= rw ? PH_TX : PH_RX;
                            tx_pend <= rw;
                            cnt     <= '0;
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            flag   <= 1'b1;
                            if (is_gc) status <= ackd ? ST_GC_ACK : ST_GC_NACK;
                            else       status <= ackd ? ST_RX_ACK : ST_RX_NACK;
                            phase  <= ackd ? PH_RX : PH_SKIP;
                        end
                    end
                    PH_TX: begin
                        if (!tx_pend) begin
                            if (ev.rise) begin
                                cnt <= cnt + 1'b1;
                            end else if (ev.fall) begin
                                if (cnt == CNT_W'(BYTE_W)) begin
                                    sda_oe <= 1'b0;
                                    phase  <= PH_TX_ACK;
                                end else begin
                                    shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                    sda_oe <= ~shreg[BYTE_W-2];
                                end
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.rise) begin
                            mack <= ~sda_i;
                        end else if (ev.fall) begin
                            flag <= 1'b1;
                            cnt  <= '0;
                            if (!mack) begin
                                status <= ST_TX_NACK;
                                phase  <= PH_SKIP;
                            end else if (last) begin
                                status <= ST_TX_LAST;
                                phase  <= PH_SKIP;
                            end else begin
                                status  <= ST_TX_ACK;
                                tx_pend <= 1'b1;
                                phase   <= PH_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_slave_engine.sv
// Top of the two-wire slave engine: line monitor, protocol core, stretch stage.
// Assumes synchronised line inputs and a one-cycle flag_clr pulse from software.
module twi_slave_engine
    import twi_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              ack_en,
    input  logic              gc_en,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq_flag,
    output logic              irq
);
    bus_ev_t ev;

    twi_slv_linemon u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    twi_slv_core u_core (
        .clk(clk), .rst_n(rst_n), .ev(ev), .sda_i(sda_i),
        .ack_en(ack_en), .gc_en(gc_en), .own_addr(own_addr), .tx_data(tx_data),
        .flag_clr(flag_clr), .status(status), .rx_data(rx_data),
        .flag(irq_flag), .sda_oe(sda_oe)
    );

    twi_slv_hold u_hold (
        .clk(clk), .rst_n(rst_n), .flag(irq_flag), .irq_en(irq_en),
        .scl_i(scl_i), .scl_oe(scl_oe), .irq(irq)
    );
endmodule

// File: rtl/twi_slave_engine_chk.sv
// Property checker for twi_slave_engine, attached by the bind below.
// Observes ports only; all properties are off during reset.
module twi_slave_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       flag_clr,
    input logic [7:0] status,
    input logic       irq_flag,
    input logic       irq
);
    // R1: a rising flag always comes with a non-idle status code.
    a_r1_flag_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> status != 8'hF8);

    // R3: SCL is only stretched while the flag is, or just was, set.
    a_r3_hold_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> (irq_flag || $past(irq_flag)));

    // R3: a clear that sticks lets SCL go two cycles later.
    a_r3_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && irq_flag) ##1 !irq_flag |=> !scl_oe);

    // R4: no interrupt without the flag, and none once the flag falls.
    a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);
    a_r4_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> !irq);

    // R11: the SDA drive moves only in a cycle where SCL was low.
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_i));
endmodule

bind twi_slave_engine twi_slave_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .flag_clr(flag_clr), .status(status), .irq_flag(irq_flag), .irq(irq)
);

// File: tb/tb_twi_slave_engine.sv
// Bench: bus-master model on a wired-AND bus plus a software model that
// services every status code; random transfers mixed with directed cases.
module tb_twi_slave_engine;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int WD_LIMIT   = 190000;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic m_scl_oe = 1'b0, m_sda_oe = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe, irq_flag, irq;
    logic ack_en = 1'b0, gc_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic [6:0] own_addr = OWN;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] status, rx_data;

    assign scl_bus = ~(m_scl_oe | scl_oe);
    assign sda_bus = ~(m_sda_oe | sda_oe);

    twi_slave_engine dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ack_en(ack_en), .gc_en(gc_en),
        .irq_en(irq_en), .own_addr(own_addr), .tx_data(tx_data),
        .flag_clr(flag_clr), .status(status), .rx_data(rx_data),
        .irq_flag(irq_flag), .irq(irq)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, viol = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Watchdog: an overlong run counts as one failed check.
    always @(negedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // R11 monitor: SDA drive must not move across a span where SCL stayed high.
    logic p_oe = 1'b0, p_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== p_oe) && p_scl && scl_bus) viol++;
        p_oe  = sda_oe;
        p_scl = scl_bus;
    end

    function automatic int exp_addr_code(input bit rd, input bit gc);
        return rd ? 'hA8 : (gc ? 'h70 : 'h60);
    endfunction
    function automatic int exp_rx_code(input bit gc, input bit ack);
        if (gc) return ack ? 'h90 : 'h98;
        return ack ? 'h80 : 'h88;
    endfunction
    function automatic int exp_tx_code(input bit mack, input bit lst);
        if (!mack) return 'hC0;
        return lst ? 'hC8 : 'hB8;
    endfunction
    function automatic bit is_terminal(input int code);
        return code == 'h88 || code == 'h98 || code == 'hA0 || code == 'hC0 || code == 'hC8;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_oe = 1'b0;
        while (scl_bus !== 1'b1) @(negedge clk);
        tick(Q);
    endtask

    task automatic m_start();
        m_sda_oe = 1'b0; tick(Q);
        scl_up();
        m_sda_oe = 1'b1; tick(Q);
        m_scl_oe = 1'b1; tick(Q);
    endtask

    task automatic m_stop();
        m_sda_oe = 1'b1; tick(Q);
        scl_up();
        m_sda_oe = 1'b0; tick(Q);
    endtask

    task automatic m_bit_w(input bit b);
        m_sda_oe = !b; tick(Q);
        scl_up();
        m_scl_oe = 1'b1; tick(Q);
    endtask

    task automatic m_bit_r(output bit b);
        m_sda_oe = 1'b0; tick(Q);
        m_scl_oe = 1'b0;
        while (scl_bus !== 1'b1) @(negedge clk);
        tick(2);
        b = sda_bus;
        tick(2);
        m_scl_oe = 1'b1; tick(Q);
    endtask

    // Sends a byte; returns the SDA level seen in the ninth clock (0 = ACK).
    task automatic m_write_byte(input logic [7:0] d, output bit nack);
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(nack);
    endtask

    task automatic m_read_byte(input bit give_ack, output logic [7:0] d);
        bit b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            m_bit_r(b);
            d = {d[6:0], b};
        end
        m_bit_w(!give_ack);
    endtask

    // Software model: checks a status code, the stretch for hold cycles, the
    // interrupt, then clears the flag.
    task automatic service(input string tag, input int exp, input int hold, input bit held);
        tick(3);
        check({tag, " status"}, status, exp);
        check({tag, " flag set"}, irq_flag, 1);
        check({"R4 irq with flag ", tag}, irq, irq_en);
        check({"R3 stretch start ", tag}, scl_oe, held);
        tick(hold);
        check({"R3 stretch held ", tag}, scl_oe, held);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        check({"R4 irq after clear ", tag}, irq, 0);
        tick(2);
        check({"R3 released ", tag}, scl_oe, 0);
        if (is_terminal(exp)) begin
            check({"R1 back to F8 ", tag}, status, 'hF8);
            check({"R1 F8 no flag ", tag}, irq_flag, 0);
        end
    endtask

    task automatic do_write(input bit gc, input int nb, input bit rand_ack, input int hold);
        bit nack, ae;
        logic [7:0] d;
        ae = 1'b1;
        ack_en = 1'b1;
        m_start();
        m_write_byte(gc ? 8'h00 : {OWN, 1'b0}, nack);
        check(gc ? "R6 gc address ACK" : "R2 own address ACK", nack, 0);
        service(gc ? "R6" : "R2", exp_addr_code(0, gc), hold, 1);
        for (int k = 0; k < nb; k++) begin
            d = 8'($urandom);
            ae = rand_ack ? 1'($urandom) : 1'b1;
            ack_en = ae;
            m_write_byte(d, nack);
            check(gc ? "R6 data ACK level" : "R5 data ACK level", nack, !ae);
            check("R5 received byte", rx_data, d);
            service(gc ? "R6" : "R5", exp_rx_code(gc, ae), hold, 1);
            if (!ae) break;
        end
        ack_en = 1'b1;
        m_stop();
        if (ae) service("R10 stop", 'hA0, 0, 0);
        else begin
            tick(3);
            check("R5 ignored after NACK", irq_flag, 0);
        end
    endtask

    task automatic do_read(input int nb, input bit last_mode, input int hold);
        bit nack, give_ack, lst;
        logic [7:0] d, got;
        ack_en = 1'b1;
        m_start();
        m_write_byte({OWN, 1'b1}, nack);
        check("R8 read address ACK", nack, 0);
        d = 8'($urandom);
        lst = last_mode && (nb == 1);
        tx_data = d;
        ack_en = !lst;
        service("R8", 'hA8, hold, 1);
        for (int k = 0; k < nb; k++) begin
            give_ack = (k < nb - 1) || last_mode;
            m_read_byte(give_ack, got);
            check("R8 sent byte", got, d);
            d = 8'($urandom);
            tx_data = d;
            ack_en = !(last_mode && (k + 1 == nb - 1));
            service(lst ? "R9" : "R8", exp_tx_code(give_ack, lst), hold, 1);
            lst = last_mode && (k + 1 == nb - 1);
        end
        ack_en = 1'b1;
        m_stop();
        tick(3);
        check("R9 no event after final byte", irq_flag, 0);
    endtask

    initial begin
        bit nack;
        void'($urandom(32'h00C0FFEE));
        tick(4);
        check("R1 reset status", status, 'hF8);
        check("R1 reset flag", irq_flag, 0);
        check("R1 reset irq", irq, 0);
        check("R1 reset scl_oe", scl_oe, 0);
        check("R1 reset sda_oe", sda_oe, 0);
        rst_n = 1'b1;
        tick(4);

        // R7: acknowledge disabled, own address ignored.
        ack_en = 1'b0;
        m_start();
        m_write_byte({OWN, 1'b0}, nack);
        check("R7 no ACK when disabled", nack, 1);
        tick(3);
        check("R7 flag stays 0", irq_flag, 0);
        check("R7 status stays F8", status, 'hF8);
        m_stop();

        // R7: wrong address.
        ack_en = 1'b1;
        m_start();
        m_write_byte({OWN ^ 7'h01, 1'b0}, nack);
        check("R7 wrong address NACK", nack, 1);
        m_stop();
        tick(3);
        check("R7 wrong address no flag", irq_flag, 0);

        // R6: general call with gc disabled.
        gc_en = 1'b0;
        m_start();
        m_write_byte(8'h00, nack);
        check("R6 gc disabled NACK", nack, 1);
        m_stop();
        tick(3);
        check("R6 gc disabled no flag", irq_flag, 0);
        gc_en = 1'b1;

        // R2/R5 directed write with a long stretch, then NACK byte.
        irq_en = 1'b1;
        do_write(0, 2, 0, 40);
        ack_en = 1'b1;
        m_start();
        m_write_byte({OWN, 1'b0}, nack);
        service("R2", 'h60, 5, 1);
        ack_en = 1'b0;
        m_write_byte(8'hA5, nack);
        check("R5 NACK level", nack, 1);
        check("R5 NACK byte data", rx_data, 'hA5);
        service("R5", 'h88, 5, 1);
        ack_en = 1'b1;
        m_stop();

        // R10: repeated START while addressed, then a new address.
        m_start();
        m_write_byte({OWN, 1'b0}, nack);
        service("R2", 'h60, 3, 1);
        m_write_byte(8'h3C, nack);
        service("R5", 'h80, 3, 1);
        m_start();
        service("R10 repeated start", 'hA0, 6, 1);
        m_write_byte({OWN, 1'b0}, nack);
        check("R10 address after restart", nack, 0);
        service("R10", 'h60, 2, 1);
        m_stop();
        service("R10 stop", 'hA0, 0, 0);

        // R8/R9 directed reads.
        do_read(2, 0, 10);
        do_read(2, 1, 10);
        do_read(1, 1, 0);

        // Random mix.
        for (int t = 0; t < 30; t++) begin
            int kind, hold;
            kind = int'($urandom % 3);
            hold = int'($urandom % 20);
            irq_en = 1'($urandom);
            case (kind)
                0: do_write(0, 1 + int'($urandom % 4), 1, hold);
                1: do_write(1, 1 + int'($urandom % 3), 1, hold);
                default: do_read(1 + int'($urandom % 3), 1'($urandom), hold);
            endcase
        end

        check("R11 SDA moved while SCL high", viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule